// File: doc/BRIEF.md
# Timer counter with delayed reload

This block is an 8-bit programmable counter with a reload value. It counts falling edges of one bit of an internal free-running divider, and a control register picks that bit. When the counter steps past its all-ones value, the reload value is loaded on the same clock edge. The interrupt that belongs to the overflow is held back, though. A separate advance strobe drives a small reload state machine. The first strobe after the wrap parks the request in a pending bit. The strobe after that releases it as a one-cycle request pulse for the interrupt controller. The pending bit is also brought out, so that a neighbour can see a request that is due but not yet released.

A register port writes the counter, the reload value and the control bits, and reads them back. A write to the control register can itself produce one count. This happens when the write takes the gated divider signal from high to low, either by turning the timer off or by moving to a tap that is currently low. A write to the counter while a reload is still settling cancels that reload and its request.

Top module: `tmr_reload_unit`

## Requirements
- R1: After reset the counter and reload value read 0x00, the control register reads 0xF8, the reload state is idle (running), and both irq_pend and irq_req are low.
- R2: Each cycle with tick high advances the divider by one. The divider is cleared only by reset. Control bit 2 enables counting. Control bits [1:0] pick the divider tap: 0 selects bit DIV_W-1, 1 selects bit 3, 2 selects bit 5 and 3 selects bit 7. The counter gains one on each high-to-low transition of (enable AND tap). With no tick and no write, the counter holds.
- R3: An increment from 0xFF loads the reload value into the counter on the same edge and enters the first reload state. No request is raised at that point.
- R4: The first step strobe in the first reload state sets irq_pend and moves to the second reload state, while irq_req stays low.
- R5: The next step strobe drives irq_req high for exactly the one cycle after it and clears irq_pend. The state machine returns to running.
- R6: rd_sel selects what is read: 0 the counter, 1 the reload value, 2 the control register with bits 7:3 reading as one, and 3 the constant 0xFF.
- R7: A control write that takes (enable AND tap) from high to low adds exactly one count, whether it clears the enable or moves to a tap that is low.
- R8: A control write that leaves (enable AND tap) high, or finds it already low, adds no count. Only the low three bits of the written value are stored.
- R9: A counter write during the first reload state cancels the reload. The state returns to running, irq_pend is cleared, later steps raise no request, and the counter keeps the written value.
- R10: A step strobe while running with nothing parked raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advances the internal divider by one |
| step | input | 1 | Advance strobe for the reload state machine |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Write target: 0 counter, 1 reload value, 2 control |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Read select: 0 counter, 1 reload value, 2 control, 3 constant |
| rd_data | output | CNT_W | Read data (combinational) |
| irq_pend | output | 1 | Parked request that is not yet released |
| irq_req | output | 1 | One-cycle timer interrupt request |

## Verification
A vector table runs the counter from reset across each of the four taps. It uses tick counts that land on, just past and between falling edges, with and without the enable, and with start values that wrap into different reload values. This separates tap mapping errors, off-by-one edge detection and a broken enable. Directed sequences then walk the overflow through both strobes and sample irq_pend and irq_req after each one, which shows whether the request is released early or late. Control writes are made with the selected tap high and with it low, and include a write that changes only the unused upper bits, so a missing glitch count and a spurious one are both caught. A counter write placed inside the first reload state shows whether the cancel works.

// File: rtl/tmr_reload_unit.sv
module tmr_reload_unit #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 10,
  parameter int TAP0  = DIV_W - 1,
  parameter int TAP1  = 3,
  parameter int TAP2  = 5,
  parameter int TAP3  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             step,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_pend,
  output logic             irq_req
);
  localparam int CTL_W = 3;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-CTL_W-1:0] CTL_PAD = '1;

  typedef enum logic [1:0] {ST_RUN, ST_LOAD, ST_SETTLE} rl_state_t;

  logic [DIV_W-1:0] div_q, div_nx;
  logic [CNT_W-1:0] cnt_q, mod_q;
  logic [CTL_W-1:0] ctl_q, ctl_nx;
  rl_state_t        st_q, st_nx;
  logic             wr_cnt, wr_mod, wr_ctl;
  logic             gate_now, gate_nx, bump, wrap, cancel;

  function automatic logic tap_of(input logic [DIV_W-1:0] d, input logic [1:0] s);
    case (s)
      2'd0:    tap_of = d[TAP0];
      2'd1:    tap_of = d[TAP1];
      2'd2:    tap_of = d[TAP2];
      default: tap_of = d[TAP3];
    endcase
  endfunction

  assign wr_cnt   = wr_en && (wr_sel == 2'd0);
  assign wr_mod   = wr_en && (wr_sel == 2'd1);
  assign wr_ctl   = wr_en && (wr_sel == 2'd2);
  assign div_nx   = div_q + {{(DIV_W-1){1'b0}}, tick};
  assign ctl_nx   = wr_ctl ? wr_data[CTL_W-1:0] : ctl_q;
  assign gate_now = ctl_q[2]  & tap_of(div_q,  ctl_q[1:0]);
  assign gate_nx  = ctl_nx[2] & tap_of(div_nx, ctl_nx[1:0]);
  assign bump     = gate_now & ~gate_nx & ~wr_cnt;
  assign wrap     = bump && (cnt_q == CNT_TOP);
  assign cancel   = wr_cnt && (st_q == ST_LOAD);

  always_comb begin
    st_nx = st_q;
    if (step) begin
      case (st_q)
        ST_LOAD:   st_nx = ST_SETTLE;
        ST_SETTLE: st_nx = ST_RUN;
        default:   st_nx = ST_RUN;
      endcase
    end
    if (wrap)   st_nx = ST_LOAD;
    if (cancel) st_nx = ST_RUN;
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = cnt_q;
      2'd1:    rd_data = mod_q;
      2'd2:    rd_data = {CTL_PAD, ctl_q};
      default: rd_data = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      cnt_q    <= '0;
      mod_q    <= '0;
      ctl_q    <= '0;
      st_q     <= ST_RUN;
      irq_pend <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      div_q <= div_nx;
      ctl_q <= ctl_nx;
      st_q  <= st_nx;
      if (wr_mod) mod_q <= wr_data;
      if (wr_cnt)    cnt_q <= wr_data;
      else if (wrap) cnt_q <= mod_q;
      else if (bump) cnt_q <= cnt_q + 1'b1;
      irq_req <= step & irq_pend;
      if (cancel)    irq_pend <= 1'b0;
      else if (step) irq_pend <= (st_q == ST_LOAD);
    end
  end

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt_q));

  a_r3_wrap_load: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (st_q == ST_LOAD) && (cnt_q == $past(mod_q)));

  a_r4_park: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st_q == ST_LOAD && !wr_cnt && !wrap) |=> (irq_pend && st_q == ST_SETTLE));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(step) && $past(irq_pend)));

  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && st_q == ST_LOAD) |=> (st_q == ST_RUN && !irq_pend && cnt_q == $past(wr_data)));
endmodule

// File: tb/tmr_reload_unit_tb.sv
module tmr_reload_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, step = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq_pend, irq_req;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  tmr_reload_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_pend(irq_pend), .irq_req(irq_req));

  // {ctrl, start count, reload value, ticks, expected count}
  localparam logic [47:0] VEC [7] = '{
    {8'h05, 8'h10, 8'h00, 16'd48,   8'h13},
    {8'h06, 8'h20, 8'h00, 16'd130,  8'h22},
    {8'h01, 8'h20, 8'h00, 16'd100,  8'h20},
    {8'h05, 8'hFE, 8'hA0, 16'd32,   8'hA0},
    {8'h07, 8'h00, 8'h00, 16'd600,  8'h02},
    {8'h04, 8'h05, 8'h00, 16'd1100, 8'h06},
    {8'h05, 8'hFF, 8'h33, 16'd16,   8'h33}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 0; step = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic stp();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    rd(2'd0, v); chk("R1 counter", v, 8'h00);
    rd(2'd1, v); chk("R1 reload", v, 8'h00);
    rd(2'd2, v); chk("R1 control", v, 8'hF8);
    chk("R1 pend", {7'd0, irq_pend}, 8'h00);
    chk("R1 req",  {7'd0, irq_req}, 8'h00);
    // R6 read paths
    rd(2'd3, v); chk("R6 constant", v, 8'hFF);
    wr(2'd1, 8'h5A); rd(2'd1, v); chk("R6 reload read", v, 8'h5A);

    // R2/R3 vector walk
    foreach (VEC[i]) begin
      do_reset();
      wr(2'd1, VEC[i][31:24]);
      wr(2'd0, VEC[i][39:32]);
      wr(2'd2, VEC[i][47:40]);
      ticks(int'(VEC[i][23:8]));
      rd(2'd0, v);
      chk($sformatf("R2/R3 vector %0d", i), v, VEC[i][7:0]);
    end

    // R3 R4 R5 delayed request
    do_reset();
    wr(2'd1, 8'h40); wr(2'd0, 8'hFF); wr(2'd2, 8'h05);
    ticks(16);
    rd(2'd0, v); chk("R3 reload loaded", v, 8'h40);
    chk("R3 no pend yet", {7'd0, irq_pend}, 8'h00);
    chk("R3 no req yet",  {7'd0, irq_req}, 8'h00);
    stp();
    chk("R4 pend set", {7'd0, irq_pend}, 8'h01);
    chk("R4 req low",  {7'd0, irq_req}, 8'h00);
    stp();
    chk("R5 req high",   {7'd0, irq_req}, 8'h01);
    chk("R5 pend clear", {7'd0, irq_pend}, 8'h00);
    @(negedge clk);
    chk("R5 req one cycle", {7'd0, irq_req}, 8'h00);
    // R10 step while running
    stp();
    chk("R10 no req", {7'd0, irq_req}, 8'h00);
    chk("R10 no pend", {7'd0, irq_pend}, 8'h00);

    // R9 cancel
    do_reset();
    wr(2'd1, 8'h40); wr(2'd0, 8'hFF); wr(2'd2, 8'h05);
    ticks(16);
    wr(2'd0, 8'h12);
    stp();
    chk("R9 no pend", {7'd0, irq_pend}, 8'h00);
    stp();
    chk("R9 no req", {7'd0, irq_req}, 8'h00);
    rd(2'd0, v); chk("R9 counter kept", v, 8'h12);

    // R7 glitch by disabling
    do_reset();
    wr(2'd2, 8'h05); ticks(8); wr(2'd2, 8'h01);
    rd(2'd0, v); chk("R7 disable glitch", v, 8'h01);
    // R7 glitch by tap change
    do_reset();
    wr(2'd2, 8'h05); ticks(8); wr(2'd2, 8'h06);
    rd(2'd0, v); chk("R7 tap change glitch", v, 8'h01);
    // R8 no glitch when gate already low
    do_reset();
    wr(2'd2, 8'h05); ticks(4); wr(2'd2, 8'h01);
    rd(2'd0, v); chk("R8 low gate no count", v, 8'h00);
    // R8 upper bits only
    do_reset();
    wr(2'd2, 8'h05); ticks(8); wr(2'd2, 8'h0D);
    rd(2'd0, v); chk("R8 same gate no count", v, 8'h00);
    rd(2'd2, v); chk("R8 control stored low bits", v, 8'hFD);

    summary();
  end
endmodule